// File: doc/BRIEF.md
# Far-End Alarm Channel Event Latch and Interrupt

This block watches the live status of a far-end alarm-and-control codeword channel and turns selected changes of that status into sticky event bits that software can read. Five events are tracked: the transmitter going idle, the receiver detecting a codeword, the receiver going idle, the receive FIFO becoming non-empty, and a codeword being dropped because the receive FIFO was full. Each event bit is set by a transition (or by the overflow strobe), not by a level. Software clears a bit by writing 1 to it.

A per-bit mask register and a master enable input decide which of the sticky bits drive the single interrupt output. Software reads the event register to find the cause, clears the bits it has handled, and the interrupt drops. The transmitter, the receiver and the FIFO are outside this block and only drive its status inputs.

Top module: `fe_alarm_irq_reg`

## Requirements
- R1: After reset the event register and the mask register read 0 and `irq` is 0.
- R2: Event bits 0 (transmit idle), 1 (codeword detected) and 2 (receive idle) set to 1 on the clock edge that samples a 0-to-1 change of `tx_idle`, `rx_cw_det` or `rx_idle` respectively; a 1-to-0 change sets nothing.
- R3: Event bit 3 (FIFO not empty) sets to 1 on the clock edge that samples a 1-to-0 change of `rx_fifo_empty`; a 0-to-1 change sets nothing.
- R4: Event bit 4 (FIFO overflow) sets to 1 on every clock edge at which the strobe `rx_fifo_ovf` is 1.
- R5: A write to the event register address (default 0x62) clears every event bit whose `host_wdata` bit is 1 and leaves the bits written with 0 unchanged.
- R6: A status input that stays high (or `rx_fifo_empty` staying low) after its bit was cleared does not set the bit again.
- R7: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up 1.
- R8: `irq` is 1 exactly when `blk_en` is 1 and at least one event bit is 1 while its mask bit is 1; it is combinational from the registers and `blk_en`.
- R9: `irq` falls in the same cycle its last contributing event bit is cleared, its mask bit is written 0, or `blk_en` goes 0.
- R10: The mask register at address 0x63 holds `host_wdata[4:0]` when written; reads of both registers return 0 in bits 7 to 5, and reads of any other address return 0.
- R11: With `rx_fifo_empty` held at 1 through and after reset, event bit 3 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_idle | input | 1 | Live transmit-idle status |
| rx_cw_det | input | 1 | Live receive codeword-detected status |
| rx_idle | input | 1 | Live receive-idle status |
| rx_fifo_empty | input | 1 | Live receive FIFO empty flag |
| rx_fifo_ovf | input | 1 | One strobe per codeword dropped on a full FIFO |
| blk_en | input | 1 | Master interrupt enable for this block |
| host_addr | input | ADDR_W | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from `host_addr` |
| irq | output | 1 | Interrupt request |

## Verification
A status change driven before a rising edge shows in the event register right after that edge, one register stage of edge history plus the latch itself; a host write likewise takes effect at the edge that samples it. Read data and `irq` follow the registers with no further delay, so the bench drives on the falling edge and samples on the following falling edge, exactly one edge later. Every mask value against every event pattern and both master enable states is swept, with the expected interrupt computed as a plain AND/OR of bench-side integers.

// File: rtl/fe_alarm_pkg.sv
package fe_alarm_pkg;

  localparam int N_EVT = 5;

  localparam int EVT_TX_IDLE  = 0;
  localparam int EVT_RX_CW    = 1;
  localparam int EVT_RX_IDLE  = 2;
  localparam int EVT_FIFO_NE  = 3;
  localparam int EVT_FIFO_OVF = 4;

  localparam int EDGE_RISE   = 0;
  localparam int EDGE_FALL   = 1;
  localparam int EDGE_STROBE = 2;

  typedef logic [N_EVT-1:0] evt_vec_t;

  function automatic int edge_kind(input int idx);
    if (idx == EVT_FIFO_NE)  return EDGE_FALL;
    if (idx == EVT_FIFO_OVF) return EDGE_STROBE;
    return EDGE_RISE;
  endfunction

  function automatic logic hist_reset(input int idx);
    return (idx == EVT_FIFO_NE) ? 1'b1 : 1'b0;
  endfunction

  // Set has priority over a clearing write in the same cycle.
  function automatic evt_vec_t latch_next(input evt_vec_t q, input evt_vec_t set_v,
                                          input evt_vec_t clr_v);
    return set_v | (q & ~clr_v);
  endfunction

  function automatic logic irq_reduce(input evt_vec_t q, input evt_vec_t mask,
                                      input logic master);
    return master & (|(q & mask));
  endfunction

endpackage

// File: rtl/fe_edge_cell.sv
module fe_edge_cell
  import fe_alarm_pkg::*;
#(
  parameter int   MODE    = EDGE_RISE,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  output logic evt
);

  generate
    if (MODE == EDGE_STROBE) begin : g_strobe
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign evt = live;
    end else begin : g_hist
      logic hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= RST_VAL;
        else        hist_q <= live;
      end
      if (MODE == EDGE_FALL) begin : g_fall
        assign evt = hist_q & ~live;
      end else begin : g_rise
        assign evt = live & ~hist_q;
      end
    end
  endgenerate

endmodule

// File: rtl/fe_latch_bank.sv
module fe_latch_bank
  import fe_alarm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t set_evt,
  input  evt_vec_t clr_req,
  output evt_vec_t lat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= latch_next(lat_q, set_evt, clr_req);
  end

endmodule

// File: rtl/fe_irq_combine.sv
module fe_irq_combine
  import fe_alarm_pkg::*;
(
  input  evt_vec_t lat_q,
  input  evt_vec_t mask_q,
  input  logic     master,
  output logic     irq
);

  assign irq = irq_reduce(lat_q, mask_q, master);

endmodule

// File: rtl/fe_alarm_irq_reg.sv
module fe_alarm_irq_reg
  import fe_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h62,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_idle,
  input  logic              rx_cw_det,
  input  logic              rx_idle,
  input  logic              rx_fifo_empty,
  input  logic              rx_fifo_ovf,
  input  logic              blk_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);

  localparam int PAD_W = DATA_W - N_EVT;

  evt_vec_t live_vec;
  evt_vec_t set_evt;
  evt_vec_t clr_req;
  evt_vec_t lat_q;
  evt_vec_t mask_q;
  logic     stat_hit;
  logic     mask_hit;
  logic     unused_wdata;

  assign live_vec[EVT_TX_IDLE]  = tx_idle;
  assign live_vec[EVT_RX_CW]    = rx_cw_det;
  assign live_vec[EVT_RX_IDLE]  = rx_idle;
  assign live_vec[EVT_FIFO_NE]  = rx_fifo_empty;
  assign live_vec[EVT_FIFO_OVF] = rx_fifo_ovf;

  genvar gi;
  generate
    for (gi = 0; gi < N_EVT; gi++) begin : g_edge
      fe_edge_cell #(
        .MODE    (edge_kind(gi)),
        .RST_VAL (hist_reset(gi))
      ) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live_vec[gi]),
        .evt   (set_evt[gi])
      );
    end
  endgenerate

  assign stat_hit     = host_wr && (host_addr == STAT_ADDR);
  assign mask_hit     = host_wr && (host_addr == MASK_ADDR);
  assign clr_req      = stat_hit ? host_wdata[N_EVT-1:0] : '0;
  assign unused_wdata = ^host_wdata[DATA_W-1:N_EVT];

  fe_latch_bank u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_req (clr_req),
    .lat_q   (lat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (mask_hit) mask_q <= host_wdata[N_EVT-1:0];
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == STAT_ADDR)      host_rdata = {{PAD_W{1'b0}}, lat_q};
    else if (host_addr == MASK_ADDR) host_rdata = {{PAD_W{1'b0}}, mask_q};
  end

  fe_irq_combine u_irq (
    .lat_q  (lat_q),
    .mask_q (mask_q),
    .master (blk_en),
    .irq    (irq)
  );

endmodule

// File: rtl/fe_alarm_irq_chk.sv
module fe_alarm_irq_chk
  import fe_alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_idle,
  input logic              rx_fifo_empty,
  input logic              rx_fifo_ovf,
  input logic              blk_en,
  input evt_vec_t          set_evt,
  input evt_vec_t          clr_req,
  input evt_vec_t          lat_q,
  input evt_vec_t          mask_q,
  input logic              irq,
  input logic [DATA_W-1:0] host_rdata
);

  genvar gb;
  generate
    for (gb = 0; gb < N_EVT; gb++) begin : g_bit
      // R7: a set event always leaves the bit at 1
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[gb] |=> lat_q[gb]);
      // R5: a clear without a competing event empties the bit
      a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[gb] && !set_evt[gb]) |=> !lat_q[gb]);
      // R6: no event and no clear means the bit holds
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req[gb] && !set_evt[gb]) |=> $stable(lat_q[gb]));
    end
  endgenerate

  // R2: a rising transmit-idle sets bit 0
  a_r2_tx_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_idle) |=> lat_q[EVT_TX_IDLE]);

  // R3: a falling empty flag sets bit 3
  a_r3_fifo_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_fifo_empty) |=> lat_q[EVT_FIFO_NE]);

  // R4: overflow strobe sets bit 4
  a_r4_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_ovf |=> lat_q[EVT_FIFO_OVF]);

  // R9: master enable low silences the interrupt
  a_r9_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |-> !irq);

  // R8: no enabled source means no interrupt
  a_r8_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & mask_q) == '0) |-> !irq);

  // R10: unused read bits are zero
  a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DATA_W-1:N_EVT] == '0);

endmodule

bind fe_alarm_irq_reg fe_alarm_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_idle       (tx_idle),
  .rx_fifo_empty (rx_fifo_empty),
  .rx_fifo_ovf   (rx_fifo_ovf),
  .blk_en        (blk_en),
  .set_evt       (set_evt),
  .clr_req       (clr_req),
  .lat_q         (lat_q),
  .mask_q        (mask_q),
  .irq           (irq),
  .host_rdata    (host_rdata)
);

// File: tb/test_fe_alarm_irq_reg.sv
`timescale 1ns/1ps
module test_fe_alarm_irq_reg;

  localparam logic [7:0] A_STAT  = 8'h62;
  localparam logic [7:0] A_MASK  = 8'h63;
  localparam int         WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_idle = 1'b0, rx_cw_det = 1'b0, rx_idle = 1'b0;
  logic       rx_fifo_empty = 1'b1, rx_fifo_ovf = 1'b0, blk_en = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fe_alarm_irq_reg i_fe_alarm_irq_reg (
    .clk (clk), .rst_n (rst_n),
    .tx_idle (tx_idle), .rx_cw_det (rx_cw_det), .rx_idle (rx_idle),
    .rx_fifo_empty (rx_fifo_empty), .rx_fifo_ovf (rx_fifo_ovf),
    .blk_en (blk_en), .host_addr (host_addr), .host_wr (host_wr),
    .host_wdata (host_wdata), .host_rdata (host_rdata), .irq (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    cyc();
    host_wr = 1'b0; host_wdata = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    host_addr = a;
    #1;
    chk(req, int'(host_rdata), exp);
  endtask

  // Drive the transitions for every bit in pat for one cycle, then restore.
  task automatic fire(input logic [4:0] pat);
    tx_idle = pat[0]; rx_cw_det = pat[1]; rx_idle = pat[2];
    rx_fifo_empty = ~pat[3]; rx_fifo_ovf = pat[4];
    cyc();
    tx_idle = 1'b0; rx_cw_det = 1'b0; rx_idle = 1'b0;
    rx_fifo_empty = 1'b1; rx_fifo_ovf = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (2) cyc();
    // R1 / R11: reset state, empty flag high through reset
    rd_chk("R1 stat after reset", A_STAT, 0);
    rd_chk("R11 no fifo bit after reset", A_STAT, 0);
    rd_chk("R1 mask after reset", A_MASK, 0);
    chk("R1 irq after reset", int'(irq), 0);

    // R2: rising edges set, falling edges do not
    tx_idle = 1'b1; cyc();
    rd_chk("R2 tx idle rise", A_STAT, 5'h01);
    rx_cw_det = 1'b1; rx_idle = 1'b1; cyc();
    rd_chk("R2 cw/idle rise", A_STAT, 5'h07);
    wr(A_STAT, 8'h07);
    tx_idle = 1'b0; rx_cw_det = 1'b0; rx_idle = 1'b0; cyc();
    rd_chk("R2 falling sets nothing", A_STAT, 0);

    // R3: empty falling sets bit 3, rising does not
    rx_fifo_empty = 1'b0; cyc();
    rd_chk("R3 empty fall", A_STAT, 5'h08);
    wr(A_STAT, 8'h08);
    // R6: empty stays low, no re-latch
    repeat (3) cyc();
    rd_chk("R6 empty held low", A_STAT, 0);
    rx_fifo_empty = 1'b1; cyc();
    rd_chk("R3 empty rise sets nothing", A_STAT, 0);

    // R4: overflow strobe
    rx_fifo_ovf = 1'b1; cyc(); rx_fifo_ovf = 1'b0;
    rd_chk("R4 ovf strobe", A_STAT, 5'h10);
    // R5: write of 0 leaves bit; write of 1 clears only that bit
    fire(5'h03);
    wr(A_STAT, 8'h00);
    rd_chk("R5 write zero keeps", A_STAT, 5'h13);
    wr(A_STAT, 8'h02);
    rd_chk("R5 partial clear", A_STAT, 5'h11);
    wr(A_STAT, 8'hFF);
    rd_chk("R5 full clear", A_STAT, 0);

    // R6: held-high codeword-detected does not re-latch
    rx_cw_det = 1'b1; cyc();
    wr(A_STAT, 8'h02);
    repeat (3) cyc();
    rd_chk("R6 held high no relatch", A_STAT, 0);
    rx_cw_det = 1'b0; cyc();

    // R7: set and clear in the same cycle; bit 1 cleared with no event
    rx_cw_det = 1'b1; cyc(); rx_cw_det = 1'b0; cyc();
    tx_idle = 1'b1;
    wr(A_STAT, 8'h03);
    rd_chk("R7 set beats clear", A_STAT, 5'h01);
    tx_idle = 1'b0;
    wr(A_STAT, 8'h1F);

    // R10: mask register read/write, pad bits, other address
    wr(A_MASK, 8'hFF);
    rd_chk("R10 mask pad zero", A_MASK, 5'h1F);
    wr(A_MASK, 8'h15);
    rd_chk("R10 mask readback", A_MASK, 5'h15);
    fire(5'h1F);
    rd_chk("R10 other addr zero", 8'h61, 0);
    rd_chk("R10 stat pad zero", A_STAT, 5'h1F);

    // R9: irq drops on clear, mask write and master off
    wr(A_MASK, 8'h04);
    blk_en = 1'b1; #1;
    chk("R8 irq on", int'(irq), 1);
    blk_en = 1'b0; #1;
    chk("R9 master off", int'(irq), 0);
    blk_en = 1'b1; cyc();
    wr(A_MASK, 8'h00);
    chk("R9 mask cleared", int'(irq), 0);
    wr(A_MASK, 8'h04);
    chk("R8 irq back", int'(irq), 1);
    wr(A_STAT, 8'h04);
    chk("R9 bit cleared", int'(irq), 0);

    // R8: sweep every event pattern x mask x master enable
    for (int p = 0; p < 32; p++) begin
      wr(A_STAT, 8'h1F);
      fire(5'(p));
      rd_chk("R2/R3/R4 pattern latch", A_STAT, p);
      for (int m = 0; m < 32; m++) begin
        for (int b = 0; b < 2; b++) begin
          blk_en = b[0];
          wr(A_MASK, 8'(m));
          chk("R8 irq sweep", int'(irq), (b == 1 && (p & m) != 0) ? 1 : 0);
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule